// File: doc/BRIEF.md
# Two-Region I2C Target with Register Block and User SRAM

This block is an I2C target that answers one fixed 7-bit device address and serves two memory regions. The first is a small register block at word addresses 0x00 to 0x1F. The second is a user SRAM at 0x20 to 0x5F. Both regions live inside the block. They are reached through a single internal byte port that the protocol engine drives.

A controller first writes a word address to load the internal pointer. Any data bytes that follow in the same transaction are stored one by one. To read, the controller issues a repeated START and a read-mode control byte, and the target returns bytes from the pointer. After every byte the pointer steps forward. At the end of a region it wraps back to that region's first address, not across the whole map.

SCL and SDA are oversampled by the system clock through a synchronizer. The target drives SDA only through an open-drain enable, which pulls the line low while it is high.

Top module: `i2c_dual_region_target`

## Requirements
- R1: Only the control byte 1101111 followed by the R/W bit is acknowledged. The byte is sent MSB first, and R/W is the last bit, with 0 meaning write and 1 meaning read. Any other control byte is not acknowledged, and every byte after it is ignored, with SDA released, until the next START.
- R2: A word address from 0x00 to 0x5F is acknowledged and loads the pointer. A word address above 0x5F is not acknowledged, and no data byte of that transaction is stored.
- R3: In a write, each data byte after the word address is acknowledged, stored at the pointer, and then the pointer advances by one.
- R4: In the register block the pointer steps from 0x1F to 0x00, for both writes and reads.
- R5: In the SRAM the pointer steps from 0x5F to 0x20, for both writes and reads.
- R6: After a repeated START and the read control byte 0xDF, the target returns the bytes from the pointer, MSB first. It keeps advancing the pointer while the controller acknowledges with a 0, and stops driving after the controller sends a NACK (a 1).
- R7: An acknowledge pulls SDA low during the ninth SCL low phase and releases it after that bit's falling SCL edge. The target never starts driving SDA while SCL is high.
- R8: There is no page limit. One burst may write all 64 SRAM bytes.
- R9: A START in any state returns the target to the control-byte phase with SDA released. A STOP returns it to idle, and a byte cut short by a STOP is not stored. After reset SDA is released.
- R10: After reset every register-block byte reads as 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sampled level of the SCL line |
| sda_i | input | 1 | Sampled level of the SDA line |
| sda_oe | output | 1 | Open-drain enable; 1 pulls SDA low |

## Verification
The assertions assume a well-behaved controller. It changes SDA only while SCL is low, except for START and STOP. It holds every SCL phase for several system clocks, longer than the synchronizer and edge-detect latency. Under these assumptions a rising drive enable always meets a low SCL, and a START always finds the engine ready to restart.

The bench drives the bus with quarter-bit phases of ten clocks. It moves SDA only a full quarter after the SCL edge. START, repeated START and STOP are issued only with SCL high. Aborted and refused transactions are therefore the only departures from a normal transfer.

// File: rtl/i2cds_pkg.sv
package i2cds_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_CTRL,
      ST_CTRL_ACK,
      ST_WADDR,
      ST_WADDR_ACK,
      ST_WDATA,
      ST_WDATA_ACK,
      ST_RDATA,
      ST_RDATA_ACK,
      ST_SKIP
   } tgt_state_e;

   localparam logic [6:0] DEV_ADDR_DEFAULT = 7'b1101111;

endpackage

// File: rtl/i2cds_line_sync.sv
module i2cds_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_in,
   input  logic sda_in,
   output logic scl_q,
   output logic sda_q,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);

   if (STAGES < 2) begin : g_bad_stages
      $error("i2cds_line_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] scl_sh, sda_sh;
   logic              scl_d, sda_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_sh <= '1;
         sda_sh <= '1;
         scl_d  <= 1'b1;
         sda_d  <= 1'b1;
      end else begin
         scl_sh <= {scl_sh[STAGES-2:0], scl_in};
         sda_sh <= {sda_sh[STAGES-2:0], sda_in};
         scl_d  <= scl_sh[STAGES-1];
         sda_d  <= sda_sh[STAGES-1];
      end
   end

   assign scl_q     = scl_sh[STAGES-1];
   assign sda_q     = sda_sh[STAGES-1];
   assign scl_rise  = scl_q & ~scl_d;
   assign scl_fall  = ~scl_q & scl_d;
   assign start_det = scl_q & scl_d & sda_d & ~sda_q;
   assign stop_det  = scl_q & scl_d & ~sda_d & sda_q;

endmodule

// File: rtl/i2cds_region_mem.sv
module i2cds_region_mem #(
   parameter int DEPTH          = 32,
   parameter int BASE           = 0,
   parameter bit CLEAR_ON_RESET = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       we,
   input  logic [7:0] waddr,
   input  logic [7:0] wdata,
   input  logic [7:0] raddr,
   output logic [7:0] rdata
);

   localparam int AW = $clog2(DEPTH);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("i2cds_region_mem: DEPTH must be a power of two of at least 2");
   end

   logic [7:0] mem [DEPTH];

   if (CLEAR_ON_RESET) begin : g_cleared
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
         end else if (we) begin
            mem[AW'(waddr - 8'(BASE))] <= wdata;
         end
      end
   end else begin : g_retained
      always_ff @(posedge clk) begin
         if (we && rst_n) mem[AW'(waddr - 8'(BASE))] <= wdata;
      end
   end

   assign rdata = mem[AW'(raddr - 8'(BASE))];

endmodule

// File: rtl/i2cds_target_fsm.sv
module i2cds_target_fsm
   import i2cds_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR  = DEV_ADDR_DEFAULT,
   parameter int         REG_BYTES = 32,
   parameter int         RAM_BYTES = 64
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_q,
   input  logic       sda_q,
   input  logic       scl_rise,
   input  logic       scl_fall,
   input  logic       start_det,
   input  logic       stop_det,
   output logic       sda_oe,
   output logic       wr_en,
   output logic [7:0] wr_addr,
   output logic [7:0] wr_data,
   output logic [7:0] rd_addr,
   input  logic [7:0] rd_data
);

   localparam int RAM_BASE = REG_BYTES;
   localparam int LAST     = REG_BYTES + RAM_BYTES - 1;

   if (REG_BYTES + RAM_BYTES > 256 || REG_BYTES < 1 || RAM_BYTES < 1) begin : g_bad_map
      $error("i2cds_target_fsm: both regions must be non-empty and fit 8-bit word addresses");
   end

   tgt_state_e state;
   logic [3:0] cnt;
   logic [7:0] shreg;
   logic [7:0] ptr;
   logic       rd_mode;
   logic       mack;

   function automatic logic [7:0] step_ptr(input logic [7:0] p);
      if (p == 8'(RAM_BASE - 1)) return 8'd0;
      else if (p == 8'(LAST))    return 8'(RAM_BASE);
      else                       return p + 8'd1;
   endfunction

   assign rd_addr = ptr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         cnt     <= '0;
         shreg   <= '0;
         ptr     <= '0;
         rd_mode <= 1'b0;
         mack    <= 1'b1;
         sda_oe  <= 1'b0;
         wr_en   <= 1'b0;
         wr_addr <= '0;
         wr_data <= '0;
      end else begin
         wr_en <= 1'b0;
         if (start_det) begin
            state  <= ST_CTRL;
            cnt    <= '0;
            sda_oe <= 1'b0;
         end else if (stop_det) begin
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
         end else begin
            unique case (state)
               ST_CTRL, ST_WADDR, ST_WDATA: begin
                  if (scl_rise) begin
                     shreg <= {shreg[6:0], sda_q};
                     cnt   <= cnt + 4'd1;
                  end else if (scl_fall && cnt == 4'd8) begin
                     cnt <= '0;
                     if (state == ST_CTRL) begin
                        if (shreg[7:1] == DEV_ADDR) begin
                           rd_mode <= shreg[0];
                           sda_oe  <= 1'b1;
                           state   <= ST_CTRL_ACK;
                        end else begin
                           state <= ST_SKIP;
                        end
                     end else if (state == ST_WADDR) begin
                        if (shreg <= 8'(LAST)) begin
                           ptr    <= shreg;
                           sda_oe <= 1'b1;
                           state  <= ST_WADDR_ACK;
                        end else begin
                           state <= ST_SKIP;
                        end
                     end else begin
                        wr_en   <= 1'b1;
                        wr_addr <= ptr;
                        wr_data <= shreg;
                        ptr     <= step_ptr(ptr);
                        sda_oe  <= 1'b1;
                        state   <= ST_WDATA_ACK;
                     end
                  end
               end
               ST_CTRL_ACK: begin
                  if (scl_fall) begin
                     if (rd_mode) begin
                        shreg  <= rd_data;
                        ptr    <= step_ptr(ptr);
                        sda_oe <= ~rd_data[7];
                        cnt    <= 4'd1;
                        state  <= ST_RDATA;
                     end else begin
                        sda_oe <= 1'b0;
                        cnt    <= '0;
                        state  <= ST_WADDR;
                     end
                  end
               end
               ST_WADDR_ACK, ST_WDATA_ACK: begin
                  if (scl_fall) begin
                     sda_oe <= 1'b0;
                     cnt    <= '0;
                     state  <= ST_WDATA;
                  end
               end
               ST_RDATA: begin
                  if (scl_fall) begin
                     if (cnt == 4'd8) begin
                        sda_oe <= 1'b0;
                        state  <= ST_RDATA_ACK;
                     end else begin
                        shreg  <= {shreg[6:0], 1'b0};
                        sda_oe <= ~shreg[6];
                        cnt    <= cnt + 4'd1;
                     end
                  end
               end
               ST_RDATA_ACK: begin
                  if (scl_rise) begin
                     mack <= sda_q;
                  end else if (scl_fall) begin
                     if (!mack) begin
                        shreg  <= rd_data;
                        ptr    <= step_ptr(ptr);
                        sda_oe <= ~rd_data[7];
                        cnt    <= 4'd1;
                        state  <= ST_RDATA;
                     end else begin
                        sda_oe <= 1'b0;
                        state  <= ST_SKIP;
                     end
                  end
               end
               default: begin
                  sda_oe <= 1'b0;
               end
            endcase
         end
      end
   end

   // R7: the drive enable only turns on while SCL is low
   assert_drive_scl_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe) |-> !scl_q);

   // R1: a refused or finished transaction never holds SDA
   assert_skip_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SKIP) |-> !sda_oe);

   // R2: storage writes stay inside the mapped word addresses
   assert_write_in_map_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (wr_addr <= 8'(LAST)));

   // R4 and R5: after a stored byte the pointer is still in that byte's region
   assert_ptr_same_region_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> ((ptr < 8'(RAM_BASE)) == (wr_addr < 8'(RAM_BASE))));

   // R9: a START always restarts the control-byte phase with SDA released
   assert_start_restarts_R9: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> (state == ST_CTRL && !sda_oe));

endmodule

// File: rtl/i2c_dual_region_target.sv
module i2c_dual_region_target
   import i2cds_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR    = DEV_ADDR_DEFAULT,
   parameter int         REG_BYTES   = 32,
   parameter int         RAM_BYTES   = 64,
   parameter int         SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_oe
);

   localparam int NUM_REGIONS = 2;

   logic       scl_q, sda_q, scl_rise, scl_fall, start_det, stop_det;
   logic       wr_en;
   logic [7:0] wr_addr, wr_data, rd_addr, rd_data;
   logic [7:0] rd_q [NUM_REGIONS];

   i2cds_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_in    (scl_i),
      .sda_in    (sda_i),
      .scl_q     (scl_q),
      .sda_q     (sda_q),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   i2cds_target_fsm #(
      .DEV_ADDR  (DEV_ADDR),
      .REG_BYTES (REG_BYTES),
      .RAM_BYTES (RAM_BYTES)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_q     (scl_q),
      .sda_q     (sda_q),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det),
      .sda_oe    (sda_oe),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .rd_addr   (rd_addr),
      .rd_data   (rd_data)
   );

   for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_region
      localparam int BASE  = (r == 0) ? 0 : REG_BYTES;
      localparam int DEPTH = (r == 0) ? REG_BYTES : RAM_BYTES;
      logic hit;
      assign hit = ({1'b0, wr_addr} >= 9'(BASE)) && ({1'b0, wr_addr} < 9'(BASE + DEPTH));

      i2cds_region_mem #(
         .DEPTH          (DEPTH),
         .BASE           (BASE),
         .CLEAR_ON_RESET (r == 0)
      ) u_mem (
         .clk   (clk),
         .rst_n (rst_n),
         .we    (wr_en && hit),
         .waddr (wr_addr),
         .wdata (wr_data),
         .raddr (rd_addr),
         .rdata (rd_q[r])
      );
   end

   assign rd_data = ({1'b0, rd_addr} < 9'(REG_BYTES)) ? rd_q[0] : rd_q[1];

endmodule

// File: tb/test_i2c_dual_region_target.sv
`timescale 1ns/1ps
module test_i2c_dual_region_target;

   localparam int Q = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_drv = 1'b1;
   logic sda_drv = 1'b1;
   logic sda_oe;
   logic sda_line;
   bit   done = 1'b0;

   assign sda_line = sda_drv & ~sda_oe;

   always #2 clk = ~clk;

   i2c_dual_region_target i_i2c_dual_region_target (
      .clk    (clk),
      .rst_n  (rst_n),
      .scl_i  (scl_drv),
      .sda_i  (sda_line),
      .sda_oe (sda_oe)
   );

   typedef struct {
      string      req;
      logic [7:0] v;
   } item_t;

   item_t      exp_q[$];
   item_t      act_q[$];
   int         checks = 0;
   int         fails  = 0;
   logic [7:0] model [96];

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   // monitor: pops results as they appear and compares them with expectations
   initial begin
      forever begin
         @(negedge clk);
         while (act_q.size() > 0 && exp_q.size() > 0) begin
            item_t a, e;
            a = act_q.pop_front();
            e = exp_q.pop_front();
            chk(e.req, a.v, e.v);
         end
      end
   end

   task automatic wt(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic int nxt(input int p);
      if (p == 31) return 0;
      if (p == 95) return 32;
      return p + 1;
   endfunction

   task automatic bus_start();
      sda_drv = 1'b1; scl_drv = 1'b1; wt(Q);
      sda_drv = 1'b0; wt(Q);
      scl_drv = 1'b0; wt(Q);
   endtask

   task automatic bus_rstart();
      sda_drv = 1'b1; wt(Q);
      scl_drv = 1'b1; wt(Q);
      sda_drv = 1'b0; wt(Q);
      scl_drv = 1'b0; wt(Q);
   endtask

   task automatic bus_stop();
      sda_drv = 1'b0; wt(Q);
      scl_drv = 1'b1; wt(Q);
      sda_drv = 1'b1; wt(Q);
   endtask

   task automatic put_bit(input logic b);
      sda_drv = b; wt(Q);
      scl_drv = 1'b1; wt(2 * Q);
      scl_drv = 1'b0; wt(Q);
   endtask

   task automatic get_bit(output logic b);
      sda_drv = 1'b1; wt(Q);
      scl_drv = 1'b1; wt(Q);
      b = sda_line; wt(Q);
      scl_drv = 1'b0; wt(Q);
   endtask

   // sends a byte, pushes the expected and observed ACK bit (0 = ACK)
   task automatic put_byte(input logic [7:0] d, input logic nack_exp, input string req,
                           input bit check_release);
      logic a;
      for (int i = 7; i >= 0; i--) put_bit(d[i]);
      get_bit(a);
      exp_q.push_back('{req, {7'd0, nack_exp}});
      act_q.push_back('{req, {7'd0, a}});
      if (check_release && !nack_exp) chk("R7 release after ack", {7'd0, sda_oe}, 8'd0);
   endtask

   task automatic get_byte(output logic [7:0] d);
      for (int i = 7; i >= 0; i--) begin
         logic b;
         get_bit(b);
         d[i] = b;
      end
   endtask

   task automatic wr_burst(input int a, input logic [7:0] d[], input string req);
      int p;
      bus_start();
      put_byte(8'hDE, 1'b0, "R1 write control", 1'b1);
      put_byte(8'(a), 1'b0, "R2 word address", 1'b1);
      p = a;
      foreach (d[i]) begin
         put_byte(d[i], 1'b0, req, 1'b1);
         model[p] = d[i];
         p = nxt(p);
      end
      bus_stop();
   endtask

   task automatic rd_burst(input int a, input int n, input string req);
      int p;
      logic [7:0] v;
      bus_start();
      put_byte(8'hDE, 1'b0, "R1 write control", 1'b1);
      put_byte(8'(a), 1'b0, "R2 word address", 1'b1);
      bus_rstart();
      put_byte(8'hDF, 1'b0, "R6 read control", 1'b0);
      p = a;
      for (int i = 0; i < n; i++) begin
         exp_q.push_back('{req, model[p]});
         get_byte(v);
         act_q.push_back('{req, v});
         p = nxt(p);
         put_bit(i == n - 1);
      end
      bus_stop();
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog R9 act=%0d exp=%0d", 1, 0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [7:0] d[];
      for (int i = 0; i < 96; i++) model[i] = (i < 32) ? 8'h00 : 8'hxx;
      wt(5);
      rst_n = 1'b1;
      wt(5);

      // R9: SDA released after reset
      chk("R9 reset release", {7'd0, sda_oe}, 8'd0);

      // R10: register block reads zero after reset
      rd_burst(0, 4, "R10 reset value");

      // R3: short burst into the register block
      d = new[3];
      foreach (d[i]) d[i] = 8'(8'hA1 + i * 17);
      wr_burst(5, d, "R3 data ack");
      rd_burst(5, 3, "R3 readback");

      // R4: register block wrap on write and read
      d = new[4];
      foreach (d[i]) d[i] = 8'(8'h3C ^ (i * 41));
      wr_burst(30, d, "R4 data ack");
      rd_burst(30, 4, "R4 wrap readback");

      // R8: whole SRAM in one burst
      d = new[64];
      foreach (d[i]) d[i] = 8'(i * 7 + 3);
      wr_burst(32, d, "R8 data ack");

      // R5: SRAM wrap on write
      d = new[3];
      foreach (d[i]) d[i] = 8'(8'hE0 + i);
      wr_burst(94, d, "R5 data ack");

      // R2: out-of-map word addresses refused, following data not stored
      bus_start();
      put_byte(8'hDE, 1'b0, "R1 write control", 1'b1);
      put_byte(8'h60, 1'b1, "R2 address 0x60 nack", 1'b0);
      put_byte(8'h55, 1'b1, "R2 data after nack", 1'b0);
      bus_stop();
      bus_start();
      put_byte(8'hDE, 1'b0, "R1 write control", 1'b1);
      put_byte(8'hFF, 1'b1, "R2 address 0xFF nack", 1'b0);
      bus_stop();

      // R1: foreign control bytes refused and the bus ignored
      bus_start();
      put_byte(8'hA0, 1'b1, "R1 foreign address nack", 1'b0);
      put_byte(8'h21, 1'b1, "R1 ignored byte", 1'b0);
      put_byte(8'h99, 1'b1, "R1 ignored byte", 1'b0);
      chk("R1 sda released", {7'd0, sda_oe}, 8'd0);
      bus_stop();
      bus_start();
      put_byte(8'hDC, 1'b1, "R1 one-bit-off address nack", 1'b0);
      bus_stop();

      // R9: byte cut short by STOP is not stored
      bus_start();
      put_byte(8'hDE, 1'b0, "R1 write control", 1'b1);
      put_byte(8'h40, 1'b0, "R2 word address", 1'b1);
      put_bit(1'b0); put_bit(1'b1); put_bit(1'b0);
      bus_stop();
      chk("R9 idle after stop", {7'd0, sda_oe}, 8'd0);

      // R9: START in the middle of a data byte restarts cleanly
      bus_start();
      put_byte(8'hDE, 1'b0, "R1 write control", 1'b1);
      put_byte(8'h41, 1'b0, "R2 word address", 1'b1);
      put_bit(1'b1); put_bit(1'b1);
      bus_rstart();
      put_byte(8'hDE, 1'b0, "R9 control after restart", 1'b1);
      put_byte(8'h10, 1'b0, "R9 address after restart", 1'b1);
      put_byte(8'h5A, 1'b0, "R9 data after restart", 1'b1);
      model[16] = 8'h5A;
      bus_stop();
      rd_burst(16, 1, "R9 restart write");

      // R6 and R8: full SRAM readback (also covers R2 and R9 no-store cases)
      rd_burst(32, 64, "R6 SRAM readback");

      // R5: SRAM wrap on read
      rd_burst(95, 3, "R5 wrap readback");

      // R6: read across register wrap starting at last address
      rd_burst(31, 2, "R6 register wrap read");

      wt(20);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule